// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits on the device side of a storage controller. It takes host register writes aimed at per-queue doorbells and keeps four ring pointers for every queue pair. The host owns the submission tail and the completion head, and it moves them by writing doorbells. The controller owns the submission head, which moves when a command is consumed, and the completion tail, which moves when a completion is posted. Queue 0 is the admin pair. Queues 1 and up carry I/O.

The doorbell window starts at byte offset 0x1000. Each queue has two consecutive slots in it: the submission-tail doorbell comes first and the completion-head doorbell second. The slot spacing in bytes is 4 shifted left by a stride-exponent input. The block checks every written value against the size configured for that queue. A write that cannot be accepted leaves all pointers unchanged and sets a sticky error flag. For each queue the block reports occupancy, empty and full status for both rings. It also gives a one-cycle pulse when a tail write leaves the submission queue holding work.

Top module: `queueDoorbellRegs`

## Requirements
- R1: For queue y, with stride = 4 << cfgStrideExp bytes, the submission-tail doorbell sits at byte address 0x1000 + 2*y*stride and the completion-head doorbell at 0x1000 + (2*y+1)*stride. An accepted write stores the low PTR_W bits of wrData into that pointer.
- R2: A write below 0x1000, or one whose offset from 0x1000 is not a multiple of the stride, changes no pointer and does not set errFlag. Decoding follows the cfgStrideExp value present in the cycle of the write.
- R3: A doorbell write whose value is equal to or above the queue's cfgQueueSize entry changes no pointer and sets errFlag.
- R4: A doorbell write to a queue whose cfgQueueValid bit is 0, or whose queue number is NUM_QUEUES or higher, changes no pointer and sets errFlag.
- R5: Once set, errFlag stays at 1 until reset, including across later valid writes.
- R6: sqCount of a queue equals (sqTail - sqHead) mod size. sqEmpty is 1 when the count is 0. sqFull is 1 when the count is size-1, so one slot is always left unused.
- R7: A high sqPop bit advances that queue's submission head by one, wrapping from size-1 to 0. The pop is ignored while the queue is empty.
- R8: A high cqPush bit advances that queue's completion tail by one with the same wrap, and is ignored while the completion ring is full. cqCount equals (cqTail - cqHead) mod size, and cqEmpty and cqFull follow the same rule as in R6.
- R9: newWork bit y is high for exactly the one cycle after an accepted submission-tail write to queue y whose value differs from the current submission head. The bit stays low otherwise, and at most one bit is high at a time.
- R10: While cfgQueueValid bit y is 0, all four pointers of queue y are held at 0.
- R11: After reset, all pointers are 0 and errFlag, newWork and rdData are 0.
- R12: rdData shows the stored doorbell pointer, zero-extended, in the cycle after rdEn with a doorbell address that decodes to an in-range queue. In every other case rdData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cfgStrideExp | input | STRIDE_EXP_W | Doorbell stride exponent; stride = 4 << value bytes |
| cfgQueueValid | input | NUM_QUEUES | Queue-created flag, one bit per queue |
| cfgQueueSize | input | NUM_QUEUES*PTR_W | Entries per queue (at least 2), queue y in bits [y*PTR_W +: PTR_W] |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write byte address |
| wrData | input | DATA_W | Register write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Register read byte address |
| rdData | output | DATA_W | Read data, one cycle after rdEn |
| sqPop | input | NUM_QUEUES | Controller consumed one submission entry |
| cqPush | input | NUM_QUEUES | Controller posted one completion entry |
| sqCount | output | NUM_QUEUES*PTR_W | Submission ring occupancy per queue |
| sqEmpty | output | NUM_QUEUES | Submission ring empty |
| sqFull | output | NUM_QUEUES | Submission ring full |
| cqCount | output | NUM_QUEUES*PTR_W | Completion ring occupancy per queue |
| cqEmpty | output | NUM_QUEUES | Completion ring empty |
| cqFull | output | NUM_QUEUES | Completion ring full |
| newWork | output | NUM_QUEUES | One-cycle pulse marking new submission work |
| errFlag | output | 1 | Sticky invalid-doorbell error |

## Verification
The assertions check these properties on every cycle:
- errFlag never drops once it is set.
- newWork is at most one-hot, and it only follows a cycle with a register write.
- Both occupancies stay below the queue size, and a ring never reports empty and full together.
- A disabled queue reports zero counts.
- rdData is zero after any cycle without a read.

Other behaviours can only be shown by the bench's scenarios:
- The exact address decode under different stride exponents.
- The rejection of misaligned, oversized and uncreated-queue writes.
- Head and tail wrap-around, and the ignored pops and pushes at the ring limits.
- The value-dependent absence of the new-work pulse.

// File: rtl/dbPkg.sv
package dbPkg;

  // Start of the doorbell window in the register space
  localparam int DB_BASE = 'h1000;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic sqTailWr;  // accepted submission-tail doorbell write
    logic cqHeadWr;  // accepted completion-head doorbell write
    logic rdHit;     // read address hits an in-range doorbell
    logic rdIsCq;    // read targets the completion-head doorbell
  } dbStrobe_t;

endpackage

// File: rtl/dbOccupancy.sv
module dbOccupancy #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] tail,
  input  logic [PTR_W-1:0] head,
  input  logic [PTR_W-1:0] size,
  output logic [PTR_W-1:0] count,
  output logic             empty,
  output logic             full
);

  // Distance from head to tail around a ring of 'size' entries
  always_comb begin
    if (tail >= head) count = tail - head;
    else              count = tail + size - head;
    empty = (count == '0);
    full  = (count == size - PTR_W'(1));
  end

endmodule

// File: rtl/dbCtrl.sv
module dbCtrl
  import dbPkg::*;
#(
  parameter int NUM_QUEUES   = 4,
  parameter int PTR_W        = 16,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int STRIDE_EXP_W = 3,
  localparam int QID_W       = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [STRIDE_EXP_W-1:0]     cfgStrideExp,
  input  logic [NUM_QUEUES-1:0]       cfgQueueValid,
  input  logic [NUM_QUEUES*PTR_W-1:0] cfgQueueSize,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           wrAddr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           rdAddr,
  output dbStrobe_t                   strobe,
  output logic [QID_W-1:0]            wrQid,
  output logic [PTR_W-1:0]            wrValue,
  output logic [QID_W-1:0]            rdQid,
  output logic                        errFlag
);

  typedef struct packed {
    logic             hit;      // inside window and stride aligned
    logic             inRange;  // queue number below NUM_QUEUES
    logic             isCq;     // odd slot: completion head
    logic [QID_W-1:0] qid;
  } decode_t;

  function automatic decode_t decodeAddr(input logic [ADDR_W-1:0] addr,
                                         input logic [STRIDE_EXP_W-1:0] se);
    decode_t          d;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] slot;
    logic [ADDR_W-1:0] qFull;
    int                sh;
    sh    = 2 + int'(se);
    off   = addr - ADDR_W'(DB_BASE);
    mask  = (ADDR_W'(1) << sh) - ADDR_W'(1);
    slot  = off >> sh;
    qFull = slot >> 1;
    d.hit     = (addr >= ADDR_W'(DB_BASE)) && ((off & mask) == '0);
    d.inRange = (qFull < ADDR_W'(NUM_QUEUES));
    d.isCq    = slot[0];
    d.qid     = qFull[QID_W-1:0];
    return d;
  endfunction

  decode_t          wrDec;
  decode_t          rdDec;
  logic [PTR_W-1:0] selSize;
  logic             selValid;
  logic             created;
  logic             valueFits;
  logic             accept;
  logic             reject;

  always_comb begin
    wrDec = decodeAddr(wrAddr, cfgStrideExp);
    rdDec = decodeAddr(rdAddr, cfgStrideExp);
  end

  // Size and created flag of the addressed queue
  always_comb begin
    selSize  = '0;
    selValid = 1'b0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (wrDec.qid == QID_W'(i)) begin
        selSize  = cfgQueueSize[i*PTR_W +: PTR_W];
        selValid = cfgQueueValid[i];
      end
    end
  end

  always_comb begin
    created   = wrDec.inRange && selValid;
    valueFits = (wrData < DATA_W'(selSize));
    accept    = wrEn && wrDec.hit && created && valueFits;
    reject    = wrEn && wrDec.hit && !(created && valueFits);
  end

  always_comb begin
    strobe.sqTailWr = accept && !wrDec.isCq;
    strobe.cqHeadWr = accept && wrDec.isCq;
    strobe.rdHit    = rdEn && rdDec.hit && rdDec.inRange;
    strobe.rdIsCq   = rdDec.isCq;
    wrQid           = wrDec.qid;
    wrValue         = wrData[PTR_W-1:0];
    rdQid           = rdDec.qid;
  end

  // Sticky error: cleared only by reset
  always_ff @(posedge clk) begin
    if (!rstN)       errFlag <= 1'b0;
    else if (reject) errFlag <= 1'b1;
  end

endmodule

// File: rtl/dbPath.sv
module dbPath
  import dbPkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int PTR_W      = 16,
  localparam int QID_W     = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int VEC_W     = NUM_QUEUES * PTR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_QUEUES-1:0] cfgQueueValid,
  input  logic [VEC_W-1:0]      cfgQueueSize,
  input  dbStrobe_t             strobe,
  input  logic [QID_W-1:0]      wrQid,
  input  logic [PTR_W-1:0]      wrValue,
  input  logic [QID_W-1:0]      rdQid,
  input  logic [NUM_QUEUES-1:0] sqPop,
  input  logic [NUM_QUEUES-1:0] cqPush,
  output logic [VEC_W-1:0]      sqCount,
  output logic [NUM_QUEUES-1:0] sqEmpty,
  output logic [NUM_QUEUES-1:0] sqFull,
  output logic [VEC_W-1:0]      cqCount,
  output logic [NUM_QUEUES-1:0] cqEmpty,
  output logic [NUM_QUEUES-1:0] cqFull,
  output logic [NUM_QUEUES-1:0] newWork,
  output logic [PTR_W-1:0]      rdPtr
);

  logic [VEC_W-1:0] sqTailVec;
  logic [VEC_W-1:0] cqHeadVec;

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gQueue
    logic [PTR_W-1:0] size;
    logic             en;
    logic             hitQ;
    logic [PTR_W-1:0] sqTail;
    logic [PTR_W-1:0] sqHead;
    logic [PTR_W-1:0] cqHead;
    logic [PTR_W-1:0] cqTail;
    logic [PTR_W-1:0] sqCnt;
    logic [PTR_W-1:0] cqCnt;
    logic             sqE;
    logic             sqF;
    logic             cqE;
    logic             cqF;
    logic             nwPulse;

    assign size = cfgQueueSize[g*PTR_W +: PTR_W];
    assign en   = cfgQueueValid[g];
    assign hitQ = (wrQid == QID_W'(g));

    dbOccupancy #(.PTR_W(PTR_W)) uSqOcc (
      .tail(sqTail), .head(sqHead), .size(size),
      .count(sqCnt), .empty(sqE), .full(sqF)
    );

    dbOccupancy #(.PTR_W(PTR_W)) uCqOcc (
      .tail(cqTail), .head(cqHead), .size(size),
      .count(cqCnt), .empty(cqE), .full(cqF)
    );

    // Host-owned pointers, moved by doorbell writes
    always_ff @(posedge clk) begin
      if (!rstN || !en) begin
        sqTail <= '0;
        cqHead <= '0;
      end else begin
        if (strobe.sqTailWr && hitQ) sqTail <= wrValue;
        if (strobe.cqHeadWr && hitQ) cqHead <= wrValue;
      end
    end

    // Controller-owned pointers, moved by consume/post events
    always_ff @(posedge clk) begin
      if (!rstN || !en) begin
        sqHead <= '0;
        cqTail <= '0;
      end else begin
        if (sqPop[g] && !sqE)
          sqHead <= (sqHead == size - PTR_W'(1)) ? '0 : sqHead + PTR_W'(1);
        if (cqPush[g] && !cqF)
          cqTail <= (cqTail == size - PTR_W'(1)) ? '0 : cqTail + PTR_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) nwPulse <= 1'b0;
      else       nwPulse <= en && strobe.sqTailWr && hitQ && (wrValue != sqHead);
    end

    assign sqCount[g*PTR_W +: PTR_W]   = sqCnt;
    assign cqCount[g*PTR_W +: PTR_W]   = cqCnt;
    assign sqTailVec[g*PTR_W +: PTR_W] = sqTail;
    assign cqHeadVec[g*PTR_W +: PTR_W] = cqHead;
    assign sqEmpty[g] = sqE;
    assign sqFull[g]  = sqF;
    assign cqEmpty[g] = cqE;
    assign cqFull[g]  = cqF;
    assign newWork[g] = nwPulse;
  end

  logic [PTR_W-1:0] rdSel;

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_QUEUES; i++) begin
      if (rdQid == QID_W'(i))
        rdSel = strobe.rdIsCq ? cqHeadVec[i*PTR_W +: PTR_W]
                              : sqTailVec[i*PTR_W +: PTR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdPtr <= '0;
    else if (strobe.rdHit) rdPtr <= rdSel;
    else                   rdPtr <= '0;
  end

endmodule

// File: rtl/queueDoorbellRegs.sv
module queueDoorbellRegs
  import dbPkg::*;
#(
  parameter int NUM_QUEUES   = 4,
  parameter int PTR_W        = 16,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int STRIDE_EXP_W = 3,
  localparam int QID_W       = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int VEC_W       = NUM_QUEUES * PTR_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [STRIDE_EXP_W-1:0] cfgStrideExp,
  input  logic [NUM_QUEUES-1:0]   cfgQueueValid,
  input  logic [VEC_W-1:0]        cfgQueueSize,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  input  logic [NUM_QUEUES-1:0]   sqPop,
  input  logic [NUM_QUEUES-1:0]   cqPush,
  output logic [VEC_W-1:0]        sqCount,
  output logic [NUM_QUEUES-1:0]   sqEmpty,
  output logic [NUM_QUEUES-1:0]   sqFull,
  output logic [VEC_W-1:0]        cqCount,
  output logic [NUM_QUEUES-1:0]   cqEmpty,
  output logic [NUM_QUEUES-1:0]   cqFull,
  output logic [NUM_QUEUES-1:0]   newWork,
  output logic                    errFlag
);

  dbStrobe_t        strobe;
  logic [QID_W-1:0] wrQid;
  logic [QID_W-1:0] rdQid;
  logic [PTR_W-1:0] wrValue;
  logic [PTR_W-1:0] rdPtr;

  dbCtrl #(
    .NUM_QUEUES(NUM_QUEUES), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STRIDE_EXP_W(STRIDE_EXP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgStrideExp(cfgStrideExp),
    .cfgQueueValid(cfgQueueValid), .cfgQueueSize(cfgQueueSize),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe),
    .wrQid(wrQid), .wrValue(wrValue), .rdQid(rdQid), .errFlag(errFlag)
  );

  dbPath #(
    .NUM_QUEUES(NUM_QUEUES), .PTR_W(PTR_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .cfgQueueValid(cfgQueueValid),
    .cfgQueueSize(cfgQueueSize), .strobe(strobe), .wrQid(wrQid),
    .wrValue(wrValue), .rdQid(rdQid), .sqPop(sqPop), .cqPush(cqPush),
    .sqCount(sqCount), .sqEmpty(sqEmpty), .sqFull(sqFull),
    .cqCount(cqCount), .cqEmpty(cqEmpty), .cqFull(cqFull),
    .newWork(newWork), .rdPtr(rdPtr)
  );

  assign rdData = DATA_W'(rdPtr);

endmodule

// File: rtl/queueDoorbellRegsChk.sv
module queueDoorbellRegsChk #(
  parameter int NUM_QUEUES   = 4,
  parameter int PTR_W        = 16,
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int STRIDE_EXP_W = 3,
  localparam int VEC_W       = NUM_QUEUES * PTR_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_QUEUES-1:0] cfgQueueValid,
  input logic [VEC_W-1:0]      cfgQueueSize,
  input logic                  wrEn,
  input logic                  rdEn,
  input logic [DATA_W-1:0]     rdData,
  input logic [VEC_W-1:0]      sqCount,
  input logic [NUM_QUEUES-1:0] sqEmpty,
  input logic [NUM_QUEUES-1:0] sqFull,
  input logic [VEC_W-1:0]      cqCount,
  input logic [NUM_QUEUES-1:0] cqEmpty,
  input logic [NUM_QUEUES-1:0] cqFull,
  input logic [NUM_QUEUES-1:0] newWork,
  input logic                  errFlag
);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);  // R5

  AST_NEWWORK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(newWork));  // R9

  AST_NEWWORK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|newWork) |-> $past(wrEn));  // R9

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> (rdData == '0));  // R12

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gChk
    logic [PTR_W-1:0] size;
    assign size = cfgQueueSize[g*PTR_W +: PTR_W];

    AST_SQ_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      (size >= PTR_W'(2)) |-> (sqCount[g*PTR_W +: PTR_W] < size));  // R6

    AST_SQ_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      (size >= PTR_W'(2)) |-> !(sqEmpty[g] && sqFull[g]));  // R6

    AST_CQ_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      (size >= PTR_W'(2)) |-> (cqCount[g*PTR_W +: PTR_W] < size));  // R8

    AST_CQ_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      (size >= PTR_W'(2)) |-> !(cqEmpty[g] && cqFull[g]));  // R8

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgQueueValid[g] && $past(!cfgQueueValid[g]))
        |-> (sqCount[g*PTR_W +: PTR_W] == '0 && cqCount[g*PTR_W +: PTR_W] == '0));  // R10
  end

endmodule

bind queueDoorbellRegs queueDoorbellRegsChk #(
  .NUM_QUEUES(NUM_QUEUES), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .STRIDE_EXP_W(STRIDE_EXP_W)
) chk (.*);

// File: tb/queueDoorbellRegs_test.sv
`timescale 1ns/1ps
module queueDoorbellRegs_test;

  localparam int NQ = 4;
  localparam int PW = 16;

  logic           clk = 1'b0;
  logic           rstN;
  logic [2:0]     cfgStrideExp;
  logic [NQ-1:0]  cfgQueueValid;
  logic [NQ*PW-1:0] cfgQueueSize;
  logic           wrEn;
  logic [15:0]    wrAddr;
  logic [31:0]    wrData;
  logic           rdEn;
  logic [15:0]    rdAddr;
  logic [31:0]    rdData;
  logic [NQ-1:0]  sqPop;
  logic [NQ-1:0]  cqPush;
  logic [NQ*PW-1:0] sqCount;
  logic [NQ-1:0]  sqEmpty;
  logic [NQ-1:0]  sqFull;
  logic [NQ*PW-1:0] cqCount;
  logic [NQ-1:0]  cqEmpty;
  logic [NQ-1:0]  cqFull;
  logic [NQ-1:0]  newWork;
  logic           errFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  queueDoorbellRegs uut (
    .clk(clk), .rstN(rstN), .cfgStrideExp(cfgStrideExp),
    .cfgQueueValid(cfgQueueValid), .cfgQueueSize(cfgQueueSize),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .sqPop(sqPop), .cqPush(cqPush),
    .sqCount(sqCount), .sqEmpty(sqEmpty), .sqFull(sqFull),
    .cqCount(cqCount), .cqEmpty(cqEmpty), .cqFull(cqFull),
    .newWork(newWork), .errFlag(errFlag)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint sqCnt(input int q);
    return longint'(sqCount[q*PW +: PW]);
  endfunction

  function automatic longint cqCnt(input int q);
    return longint'(cqCount[q*PW +: PW]);
  endfunction

  // Queue sizes: q0=8, q1=16, q2=4, q3=8; q3 not created
  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cfgStrideExp = 3'd0;
    cfgQueueValid = 4'b0111;
    cfgQueueSize = {16'd8, 16'd4, 16'd16, 16'd8};
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
    rdEn = 1'b0; rdAddr = '0;
    sqPop = '0; cqPush = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic dbWrite(input logic [15:0] a, input logic [31:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic dbRead(input logic [15:0] a, output logic [31:0] v);
    rdAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic popSq(input int q, input int n);
    sqPop = NQ'(1) << q;
    repeat (n) @(negedge clk);
    sqPop = '0;
  endtask

  task automatic pushCq(input int q, input int n);
    cqPush = NQ'(1) << q;
    repeat (n) @(negedge clk);
    cqPush = '0;
  endtask

  task automatic testReset();
    doReset();
    check("R11", "errFlag", errFlag, 0);
    check("R11", "newWork", newWork, 0);
    check("R11", "rdData", rdData, 0);
    check("R11", "sqEmpty", sqEmpty, 4'hF);
    check("R11", "cqCount", cqCount, 0);
  endtask

  task automatic testAddressing();
    logic [31:0] v;
    doReset();
    dbWrite(16'h1008, 32'd5);                 // q1 submission tail, stride 4
    check("R9", "pulse after q1 tail write", newWork, 4'b0010);
    check("R6", "q1 sqCount", sqCnt(1), 5);
    @(negedge clk);
    check("R9", "pulse lasts one cycle", newWork, 0);
    dbRead(16'h1008, v);
    check("R1", "q1 tail readback", v, 5);
    dbWrite(16'h100C, 32'd3);                 // q1 completion head
    check("R8", "q1 cqCount wrap (0-3 mod 16)", cqCnt(1), 13);
    check("R9", "no pulse on head write", newWork, 0);
    dbRead(16'h100C, v);
    check("R1", "q1 cq head readback", v, 3);
    check("R12", "rdData back to zero", 0, 0);
    @(negedge clk);
    check("R12", "rdData idle", rdData, 0);
    check("R1", "no error", errFlag, 0);
  endtask

  task automatic testStride();
    logic [31:0] v;
    doReset();
    cfgStrideExp = 3'd2;                      // stride 16 bytes
    dbWrite(16'h1040, 32'd3);                 // q2 submission tail
    check("R1", "q2 sqCount at stride 16", sqCnt(2), 3);
    check("R6", "q2 full at size-1", sqFull[2], 1);
    dbWrite(16'h1044, 32'd1);                 // misaligned
    check("R2", "misaligned write ignored", sqCnt(2), 3);
    dbWrite(16'h0FFC, 32'd1);                 // below window
    check("R2", "no error for non-doorbell writes", errFlag, 0);
    dbWrite(16'h1010, 32'd6);                 // slot 1 = q0 completion head
    check("R2", "q0 cqCount via stride-16 decode", cqCnt(0), 2);
    check("R2", "q2 untouched", sqCnt(2), 3);
    dbRead(16'h1040, v);
    check("R1", "q2 tail readback", v, 3);
  endtask

  task automatic testBadValue();
    doReset();
    dbWrite(16'h1000, 32'd8);                 // size of q0 is 8
    check("R3", "err on value == size", errFlag, 1);
    check("R3", "q0 tail unchanged", sqCnt(0), 0);
    check("R3", "no pulse", newWork, 0);
    dbWrite(16'h1000, 32'd2);
    check("R5", "valid write accepted", sqCnt(0), 2);
    check("R5", "err still set", errFlag, 1);
  endtask

  task automatic testUncreated();
    doReset();
    dbWrite(16'h1018, 32'd1);                 // q3, not created
    check("R4", "err on uncreated queue", errFlag, 1);
    check("R4", "q3 tail unchanged", sqCnt(3), 0);
    doReset();
    dbWrite(16'h1028, 32'd1);                 // queue 5 does not exist
    check("R4", "err on out-of-range queue", errFlag, 1);
    repeat (3) @(negedge clk);
    check("R5", "err held while idle", errFlag, 1);
  endtask

  task automatic testPop();
    doReset();
    dbWrite(16'h1000, 32'd7);
    check("R6", "q0 count 7", sqCnt(0), 7);
    check("R6", "q0 full", sqFull[0], 1);
    popSq(0, 7);
    check("R7", "q0 empty after 7 pops", sqEmpty[0], 1);
    popSq(0, 2);
    check("R7", "pops on empty ignored", sqCnt(0), 0);
    dbWrite(16'h1000, 32'd7);                 // tail equals head 7
    check("R9", "no pulse when tail equals head", newWork, 0);
    dbWrite(16'h1000, 32'd2);
    check("R9", "pulse on q0", newWork, 4'b0001);
    check("R7", "count after head wrap (2-7 mod 8)", sqCnt(0), 3);
    popSq(0, 2);                              // head 7 -> 0 -> 1
    check("R7", "head wrapped to 1", sqCnt(0), 1);
  endtask

  task automatic testCompletion();
    doReset();
    pushCq(1, 3);
    check("R8", "q1 cqCount 3", cqCnt(1), 3);
    dbWrite(16'h100C, 32'd2);
    check("R8", "q1 cqCount after head write", cqCnt(1), 1);
    pushCq(2, 5);
    check("R8", "q2 cqCount capped at 3", cqCnt(2), 3);
    check("R8", "q2 cq full", cqFull[2], 1);
    dbWrite(16'h1014, 32'd3);
    check("R8", "q2 cq empty (tail stopped at 3)", cqEmpty[2], 1);
  endtask

  task automatic testDisable();
    logic [31:0] v;
    doReset();
    dbWrite(16'h1008, 32'd4);
    pushCq(1, 2);
    check("R10", "q1 count before disable", sqCnt(1), 4);
    cfgQueueValid = 4'b0101;
    @(negedge clk);
    check("R10", "q1 sqCount cleared", sqCnt(1), 0);
    check("R10", "q1 cqCount cleared", cqCnt(1), 0);
    cfgQueueValid = 4'b0111;
    dbRead(16'h1008, v);
    check("R10", "q1 tail reads 0", v, 0);
  endtask

  task automatic testReadMiss();
    logic [31:0] v;
    doReset();
    dbWrite(16'h1000, 32'd5);
    dbRead(16'h0800, v);
    check("R12", "read below window", v, 0);
    dbRead(16'h1028, v);
    check("R12", "read out-of-range queue", v, 0);
    dbRead(16'h1002, v);
    check("R12", "read misaligned", v, 0);
    dbRead(16'h1000, v);
    check("R12", "read q0 tail", v, 5);
  endtask

  initial begin
    testReset();
    testAddressing();
    testStride();
    testBadValue();
    testUncreated();
    testPop();
    testCompletion();
    testDisable();
    testReadMiss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule